// File: doc/BRIEF.md
# Frame-Rate-Control Dithering Engine

This block turns 4-bit shade levels into a per-frame on/off decision for each pixel of a passive-matrix LCD and packs those decisions onto the panel data bus. Intermediate shades come from time dithering: each shade selects one of several programmable pattern registers. Each register stores a short sequence of 4-bit nibbles. The engine steps to the next nibble of every sequence at each start of frame and returns to the first nibble after the last one. Inside a nibble, the pixel's horizontal position modulo 4 picks the bit that decides whether the pixel is lit. Two shades whose duty cycles add up to one share a register. The shade in the lower half of the range uses the inverted nibble.

Upstream logic presents one pixel per valid cycle. A pixel carries its shade values and the two low bits of its column. Start-of-frame and start-of-line strobes come in alongside. In monochrome mode each pixel produces one bit. In colour mode each pixel produces three bits, red then green then blue, and each component is dithered on its own. The bits fill a 4-bit or 8-bit word starting at the top line. A full word leaves the block with a one-cycle valid pulse. A simple write port loads the pattern registers. A new pattern waits until the next start of frame. For a dual-scan panel, each half uses one instance of the block.

Top module: `frc_dither_engine`

## Requirements
- R1: After reset, lcd_valid and lcd_data are 0. Every pattern register holds all-zero nibbles with a sequence length of 1, and every register is at nibble 0.
- R2: Shade 0 always gives an off bit and shade 15 always gives an on bit, whatever the registers hold.
- R3: A pixel whose pix_x equals m (0 to 3) takes bit (3 - m) of the nibble that its register currently selects.
- R4: Shades 8 to 14 use register (shade - 8) unchanged. Shades 1 to 7 use register (7 - shade) with all four nibble bits inverted.
- R5: Each register moves to its next nibble on every sof and wraps to nibble 0 after nibble (length - 1). A written length of 0 is stored as 1.
- R6: A write selects a register with wr_sel and carries nibble i in wr_pattern[4i+3:4i] and the sequence length in wr_len. The old pattern stays in use until the next sof. At that sof the new pattern is installed and the register restarts at nibble 0. A second write before that sof replaces the first.
- R7: A pixel presented in the same cycle as sof is dithered with the state of the new frame.
- R8: When color_mode is 1, a pixel gives three bits in the order red (pix_shade[11:8]), green (pix_shade[7:4]), blue (pix_shade[3:0]), each from its own shade. When color_mode is 0, only pix_shade[3:0] is used and the upper shade fields have no effect.
- R9: The first bit of a word goes to lcd_data[BUS_W-1] and later bits fill downward. When a word fills, lcd_valid pulses for one cycle, two clock edges after the pixel that completed the word. lcd_data is 0 when lcd_valid is low.
- R10: An sof or sol discards a partly filled word. The bits of a pixel presented with the strobe start a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| color_mode | input | 1 | 1: three components per pixel; 0: monochrome |
| sof | input | 1 | Start-of-frame strobe |
| sol | input | 1 | Start-of-line strobe |
| pix_valid | input | 1 | A pixel is present this cycle |
| pix_x | input | 2 | Pixel column modulo 4 |
| pix_shade | input | 3*SHADE_W | Shades: red [11:8], green [7:4], blue or mono [3:0] |
| wr_en | input | 1 | Pattern register write strobe |
| wr_sel | input | SEL_W | Register index for the write |
| wr_len | input | LEN_W | Number of nibbles in the written sequence |
| wr_pattern | input | 4*MAX_LEN | Nibble sequence, nibble 0 in the low bits |
| lcd_data | output | BUS_W | Packed panel data word |
| lcd_valid | output | 1 | lcd_data holds a complete word |

## Verification
A wrong phase counter or a missed wrap shows on the first word holding that shade after the bad sof, so the error appears within one frame. A pending pattern that is installed too early or too late changes the words of the frame right around the write. A fill counter that slips after a strobe shifts every later word on that line and adds or drops words, and the mismatch shows within one word. A mistake in the shade-to-register table or the inversion flips bits on the first pixel of the affected shade, two cycles after it enters.

// File: rtl/frc_dither_pkg.sv
package frc_dither_pkg;
   localparam int NIB_W = 4;   // bits per dithering nibble, one per column phase
   localparam int NUM_COMP = 3; // colour components per pixel
   typedef logic [NIB_W-1:0] nibble_t;

   // pick the bit for column phase pos: phase 0 reads the top bit
   function automatic logic nib_pick(input nibble_t nib, input logic [1:0] pos);
      logic r;
      unique case (pos)
         2'd0: r = nib[3];
         2'd1: r = nib[2];
         2'd2: r = nib[1];
         default: r = nib[0];
      endcase
      return r;
   endfunction
endpackage

// File: rtl/frc_pattern_bank.sv
module frc_pattern_bank
   import frc_dither_pkg::*;
#(
   parameter int NUM_REGS = 7,
   parameter int MAX_LEN = 7,
   parameter int SEL_W = 3,
   parameter int LEN_W = 3,
   localparam int PAT_W = MAX_LEN * NIB_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sof,
   input  logic                      wr_en,
   input  logic [SEL_W-1:0]          wr_sel,
   input  logic [LEN_W-1:0]          wr_len,
   input  logic [PAT_W-1:0]          wr_pattern,
   output logic [NUM_REGS*NIB_W-1:0] cur_nibs
);
   // sequence length clamp: 0 becomes 1, overlong becomes MAX_LEN
   logic [LEN_W-1:0] wr_len_sat;
   always_comb begin
      if (wr_len == '0) wr_len_sat = LEN_W'(1);
      else if (wr_len > LEN_W'(MAX_LEN)) wr_len_sat = LEN_W'(MAX_LEN);
      else wr_len_sat = wr_len;
   end

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic [PAT_W-1:0] pat_q, pend_pat_q, eff_pat;
      logic [LEN_W-1:0] len_q, pend_len_q, phase_q, phase_inc, eff_phase;
      logic             pend_q, hit;
      nibble_t          nib;

      assign hit = wr_en && (wr_sel == SEL_W'(r));

      always_comb begin
         phase_inc = LEN_W'(phase_q + LEN_W'(1));
         if (phase_inc >= len_q) phase_inc = '0;
      end

      // the frame starting this cycle already sees its own nibble
      always_comb begin
         eff_pat = pat_q;
         eff_phase = phase_q;
         if (sof) begin
            if (pend_q) begin
               eff_pat = pend_pat_q;
               eff_phase = '0;
            end else begin
               eff_phase = phase_inc;
            end
         end
      end

      always_comb begin
         nib = '0;
         for (int i = 0; i < MAX_LEN; i++) begin
            if (eff_phase == LEN_W'(i)) nib = eff_pat[i*NIB_W +: NIB_W];
         end
      end

      assign cur_nibs[r*NIB_W +: NIB_W] = nib;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pat_q      <= '0;
            len_q      <= LEN_W'(1);
            phase_q    <= '0;
            pend_q     <= 1'b0;
            pend_pat_q <= '0;
            pend_len_q <= LEN_W'(1);
         end else begin
            if (sof) begin
               if (pend_q) begin
                  pat_q   <= pend_pat_q;
                  len_q   <= pend_len_q;
                  phase_q <= '0;
                  pend_q  <= 1'b0;
               end else begin
                  phase_q <= phase_inc;
               end
            end
            if (hit) begin
               pend_q     <= 1'b1;
               pend_pat_q <= wr_pattern;
               pend_len_q <= wr_len_sat;
            end
         end
      end
   end
endmodule

// File: rtl/frc_shade_lookup.sv
module frc_shade_lookup
   import frc_dither_pkg::*;
#(
   parameter int SHADE_W = 4,
   parameter int NUM_REGS = 7,
   localparam int MID = 2 ** (SHADE_W - 1),
   localparam int FULL = 2 ** SHADE_W - 1
) (
   input  logic [SHADE_W-1:0]        shade,
   input  logic [1:0]                pos,
   input  logic [NUM_REGS*NIB_W-1:0] nibs,
   output logic                      on_bit
);
   logic [SHADE_W-1:0] idx;
   logic               inv;
   nibble_t            nib;

   always_comb begin
      // upper half direct, lower half mirrored onto the same registers
      inv = (shade < SHADE_W'(MID));
      if (inv) idx = SHADE_W'(MID - 1) - shade;
      else idx = shade - SHADE_W'(MID);
      nib = '0;
      for (int r = 0; r < NUM_REGS; r++) begin
         if (idx == SHADE_W'(r)) nib = nibs[r*NIB_W +: NIB_W];
      end
      nib = nib ^ {NIB_W{inv}};
      if (shade == '0) on_bit = 1'b0;
      else if (shade == SHADE_W'(FULL)) on_bit = 1'b1;
      else on_bit = nib_pick(nib, pos);
   end
endmodule

// File: rtl/frc_bus_packer.sv
module frc_bus_packer #(
   parameter int BUS_W = 4,
   parameter int SEQ_W = 3,
   localparam int FILL_W = $clog2(BUS_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             in_valid,
   input  logic             in_multi,
   input  logic [SEQ_W-1:0] in_seq,
   output logic [BUS_W-1:0] word,
   output logic             word_valid
);
   logic [BUS_W-1:0]  acc_q, acc_d, word_d;
   logic [FILL_W-1:0] fill_q, fill_d;
   logic              done;

   always_comb begin
      acc_d  = clr ? '0 : acc_q;
      fill_d = clr ? '0 : fill_q;
      done   = 1'b0;
      word_d = '0;
      if (in_valid) begin
         for (int k = 0; k < SEQ_W; k++) begin
            if (k == 0 || in_multi) begin
               for (int j = 0; j < BUS_W; j++) begin
                  if (fill_d == FILL_W'(j)) acc_d[BUS_W-1-j] = in_seq[SEQ_W-1-k];
               end
               fill_d = FILL_W'(fill_d + 1'b1);
               if (fill_d == FILL_W'(BUS_W)) begin
                  done   = 1'b1;
                  word_d = acc_d;
                  acc_d  = '0;
                  fill_d = '0;
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q      <= '0;
         fill_q     <= '0;
         word       <= '0;
         word_valid <= 1'b0;
      end else begin
         acc_q      <= acc_d;
         fill_q     <= fill_d;
         word       <= done ? word_d : '0;
         word_valid <= done;
      end
   end
endmodule

// File: rtl/frc_dither_engine.sv
module frc_dither_engine
   import frc_dither_pkg::*;
#(
   parameter int SHADE_W = 4,
   parameter int MAX_LEN = 7,
   parameter int BUS_W = 4,
   localparam int NUM_REGS = 2 ** (SHADE_W - 1) - 1,
   localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   localparam int LEN_W = $clog2(MAX_LEN + 1),
   localparam int PAT_W = MAX_LEN * NIB_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  color_mode,
   input  logic                  sof,
   input  logic                  sol,
   input  logic                  pix_valid,
   input  logic [1:0]            pix_x,
   input  logic [3*SHADE_W-1:0]  pix_shade,
   input  logic                  wr_en,
   input  logic [SEL_W-1:0]      wr_sel,
   input  logic [LEN_W-1:0]      wr_len,
   input  logic [PAT_W-1:0]      wr_pattern,
   output logic [BUS_W-1:0]      lcd_data,
   output logic                  lcd_valid
);
   // elaboration-time parameter checks
   if (!(BUS_W == 4 || BUS_W == 8)) begin : g_bad_bus
      $error("frc_dither_engine: BUS_W must be 4 or 8");
   end
   if (SHADE_W < 2) begin : g_bad_shade
      $error("frc_dither_engine: SHADE_W must be at least 2");
   end
   if (MAX_LEN < 1) begin : g_bad_len
      $error("frc_dither_engine: MAX_LEN must be at least 1");
   end

   logic [NUM_REGS*NIB_W-1:0] cur_nibs;
   logic [NUM_COMP-1:0]       comb_bit;
   logic [NUM_COMP-1:0]       comp_bit_q;
   logic                      comp_valid_q, multi_q, clr_q;
   logic [NUM_COMP-1:0]       seq;

   frc_pattern_bank #(
      .NUM_REGS(NUM_REGS), .MAX_LEN(MAX_LEN), .SEL_W(SEL_W), .LEN_W(LEN_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .sof(sof), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_len(wr_len), .wr_pattern(wr_pattern), .cur_nibs(cur_nibs)
   );

   // one lookup per component; index 2 is red, 0 is blue or mono
   for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
      frc_shade_lookup #(.SHADE_W(SHADE_W), .NUM_REGS(NUM_REGS)) u_lk (
         .shade(pix_shade[c*SHADE_W +: SHADE_W]), .pos(pix_x),
         .nibs(cur_nibs), .on_bit(comb_bit[c])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         comp_bit_q   <= '0;
         comp_valid_q <= 1'b0;
         multi_q      <= 1'b0;
         clr_q        <= 1'b0;
      end else begin
         comp_bit_q   <= comb_bit;
         comp_valid_q <= pix_valid;
         multi_q      <= color_mode;
         clr_q        <= sof | sol;
      end
   end

   // first bit into the packer sits in the top position of seq
   assign seq = multi_q ? comp_bit_q : {comp_bit_q[0], {(NUM_COMP-1){1'b0}}};

   frc_bus_packer #(.BUS_W(BUS_W), .SEQ_W(NUM_COMP)) u_pack (
      .clk(clk), .rst_n(rst_n), .clr(clr_q), .in_valid(comp_valid_q),
      .in_multi(multi_q), .in_seq(seq), .word(lcd_data), .word_valid(lcd_valid)
   );
endmodule

// File: rtl/frc_dither_checker.sv
module frc_dither_checker #(
   parameter int SHADE_W = 4,
   localparam int FULL = 2 ** SHADE_W - 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 color_mode,
   input logic                 pix_valid,
   input logic [3*SHADE_W-1:0] pix_shade,
   input logic [2:0]           comp_bit,
   input logic                 comp_valid,
   input logic                 lcd_valid,
   input logic                 lcd_data_nz
);
   logic [SHADE_W-1:0] sh_r, sh_g, sh_b;
   assign sh_r = pix_shade[2*SHADE_W +: SHADE_W];
   assign sh_g = pix_shade[SHADE_W +: SHADE_W];
   assign sh_b = pix_shade[0 +: SHADE_W];

   assert_shade_zero_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid && sh_b == '0 |=> !comp_bit[0]);

   assert_shade_full_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid && sh_b == SHADE_W'(FULL) |=> comp_bit[0]);

   assert_pair_inverse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid && sh_r != '0 && sh_r != SHADE_W'(FULL) && sh_g == SHADE_W'(FULL) - sh_r
      |=> comp_bit[2] != comp_bit[1]);

   assert_same_shade_same_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid && color_mode && sh_r == sh_g |=> comp_bit[2] == comp_bit[1]);

   assert_word_after_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_valid |-> $past(comp_valid));

   assert_data_zero_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !lcd_valid |-> !lcd_data_nz);

   assert_bits_need_pixel_R9: assert property (@(posedge clk) disable iff (!rst_n)
      comp_valid |-> $past(pix_valid));
endmodule

bind frc_dither_engine frc_dither_checker #(.SHADE_W(SHADE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .color_mode(color_mode), .pix_valid(pix_valid),
   .pix_shade(pix_shade), .comp_bit(comp_bit_q), .comp_valid(comp_valid_q),
   .lcd_valid(lcd_valid), .lcd_data_nz(|lcd_data)
);

// File: tb/frc_dither_engine_tb_top.sv
module frc_dither_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        color_mode = 1'b0;
   logic        sof = 1'b0, sol = 1'b0, pix_valid = 1'b0, wr_en = 1'b0;
   logic [1:0]  pix_x = '0;
   logic [11:0] pix_shade = '0;
   logic [2:0]  wr_sel = '0;
   logic [2:0]  wr_len = '0;
   logic [27:0] wr_pattern = '0;
   logic [3:0]  lcd_data;
   logic        lcd_valid;

   always #10 clk = ~clk; // 50 MHz

   frc_dither_engine dut_i (
      .clk(clk), .rst_n(rst_n), .color_mode(color_mode), .sof(sof), .sol(sol),
      .pix_valid(pix_valid), .pix_x(pix_x), .pix_shade(pix_shade), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_len(wr_len), .wr_pattern(wr_pattern),
      .lcd_data(lcd_data), .lcd_valid(lcd_valid)
   );

   int checks = 0;
   int fails = 0;
   string cur_req = "R1";

   // reference model state
   logic [27:0] mpat[7], ppat[7];
   int          mlen[7], plen[7], mph[7];
   bit          mpend[7];
   logic [3:0]  macc;
   int          mfill;
   logic [3:0]  expq[$];

   function automatic bit exp_bit(input int s, input int x);
      int r;
      logic [3:0] nib;
      if (s == 0) return 1'b0;
      if (s == 15) return 1'b1;
      r = (s >= 8) ? s - 8 : 7 - s;
      nib = mpat[r][mph[r]*4 +: 4];
      if (s < 8) nib = ~nib;
      return nib[3 - (x % 4)];
   endfunction

   task automatic push_bit(input bit b);
      macc[3 - mfill] = b;
      mfill++;
      if (mfill == 4) begin
         expq.push_back(macc);
         macc = '0;
         mfill = 0;
      end
   endtask

   task automatic model_pixel(input int x, input logic [11:0] sh);
      if (color_mode) begin
         push_bit(exp_bit(int'(sh[11:8]), x));
         push_bit(exp_bit(int'(sh[7:4]), x));
         push_bit(exp_bit(int'(sh[3:0]), x));
      end else begin
         push_bit(exp_bit(int'(sh[3:0]), x));
      end
   endtask

   task automatic model_frame();
      for (int r = 0; r < 7; r++) begin
         if (mpend[r]) begin
            mpat[r] = ppat[r]; mlen[r] = plen[r]; mph[r] = 0; mpend[r] = 0;
         end else begin
            mph[r] = (mph[r] + 1) % mlen[r];
         end
      end
      macc = '0; mfill = 0;
   endtask

   task automatic drive(input bit p, input bit f, input bit l, input int x, input logic [11:0] sh);
      @(negedge clk);
      pix_valid = p; sof = f; sol = l; pix_x = 2'(x); pix_shade = sh; wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 12'h000);
   endtask

   task automatic frame_go();
      drive(0, 1, 0, 0, 12'h000);
      model_frame();
   endtask

   task automatic line_go();
      drive(0, 0, 1, 0, 12'h000);
      macc = '0; mfill = 0;
   endtask

   task automatic pixel(input int x, input logic [11:0] sh);
      drive(1, 0, 0, x, sh);
      model_pixel(x, sh);
   endtask

   task automatic sof_pixel(input int x, input logic [11:0] sh);
      drive(1, 1, 0, x, sh);
      model_frame();
      model_pixel(x, sh);
   endtask

   task automatic sol_pixel(input int x, input logic [11:0] sh);
      drive(1, 0, 1, x, sh);
      macc = '0; mfill = 0;
      model_pixel(x, sh);
   endtask

   task automatic write_reg(input int sel, input int len, input logic [27:0] pat);
      @(negedge clk);
      pix_valid = 0; sof = 0; sol = 0; wr_en = 1'b1;
      wr_sel = 3'(sel); wr_len = 3'(len); wr_pattern = pat;
      ppat[sel] = pat; plen[sel] = (len == 0) ? 1 : len; mpend[sel] = 1;
   endtask

   task automatic end_phase();
      idle(4);
      checks++;
      if (expq.size() != 0) begin
         fails++;
         $display("FAIL %s: %0d words missing, expected 0 outstanding", cur_req, expq.size());
      end
      expq.delete();
   endtask

   // output monitor, sampled on the falling edge
   always @(negedge clk) begin
      if (rst_n && lcd_valid) begin
         checks++;
         if (expq.size() == 0) begin
            fails++;
            $display("FAIL %s: unexpected word %h, expected none", cur_req, lcd_data);
         end else begin
            logic [3:0] e;
            e = expq.pop_front();
            if (lcd_data !== e) begin
               fails++;
               $display("FAIL %s: lcd_data=%h expected %h", cur_req, lcd_data, e);
            end
         end
      end
   end

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      for (int r = 0; r < 7; r++) begin
         mpat[r] = '0; ppat[r] = '0; mlen[r] = 1; plen[r] = 1; mph[r] = 0; mpend[r] = 0;
      end
      macc = '0; mfill = 0;
      repeat (3) @(negedge clk);
      // R1: reset state at the ports
      checks++;
      if (lcd_valid !== 1'b0 || lcd_data !== 4'h0) begin
         fails++;
         $display("FAIL R1: valid=%b data=%h expected 0/0", lcd_valid, lcd_data);
      end
      rst_n = 1'b1;
      idle(2);
      checks++;
      if (lcd_valid !== 1'b0 || lcd_data !== 4'h0) begin
         fails++;
         $display("FAIL R1: after release valid=%b data=%h expected 0/0", lcd_valid, lcd_data);
      end
      // R1: cleared registers -> upper shades off, lower shades on
      cur_req = "R1";
      for (int s = 1; s < 15; s++)
         for (int x = 0; x < 4; x++) pixel(x, {4'(s * 3), 4'(s * 5), 4'(s)});
      end_phase();

      // R5: the 3/5 and 2/3 sequences across frames, plus length 0
      cur_req = "R5";
      write_reg(1, 5, 28'h00F5A5A);
      write_reg(2, 3, 28'h00006BD);
      write_reg(3, 0, 28'h0000009);
      frame_go();
      for (int f = 0; f < 12; f++) begin
         for (int x = 0; x < 8; x++) pixel(x, 12'h009);
         for (int x = 0; x < 4; x++) pixel(x, 12'h00A);
         for (int x = 0; x < 4; x++) pixel(x, 12'h00B);
         frame_go();
      end
      end_phase();

      // R3 / R4: sweep all shades, positions, frames with computed patterns
      cur_req = "R4";
      for (int r = 0; r < 7; r++) begin
         logic [27:0] p;
         for (int i = 0; i < 7; i++) p[i*4 +: 4] = 4'((r * 7 + i * 5 + 3) % 16);
         write_reg(r, r + 1, p);
      end
      frame_go();
      for (int f = 0; f < 14; f++) begin
         for (int s = 0; s < 16; s++)
            for (int x = 0; x < 4; x++) pixel(x, {4'(15 - s), 4'(x * 4), 4'(s)});
         frame_go();
      end
      end_phase();

      // R2: extremes stay constant whatever the registers hold
      cur_req = "R2";
      for (int f = 0; f < 5; f++) begin
         for (int x = 0; x < 4; x++) pixel(x, 12'h000);
         for (int x = 0; x < 4; x++) pixel(x, 12'h00F);
         for (int x = 0; x < 4; x++) pixel(x, {4'(x), 4'hF, (x % 2 == 0) ? 4'h0 : 4'hF});
         frame_go();
      end
      end_phase();

      // R6: mid-frame write waits for sof; second write replaces first
      cur_req = "R6";
      frame_go();
      for (int x = 0; x < 4; x++) pixel(x, 12'h00C);
      write_reg(4, 4, 28'h0001234);
      for (int x = 0; x < 4; x++) pixel(x, 12'h00C);
      write_reg(4, 2, 28'h00000C3);
      for (int x = 0; x < 4; x++) pixel(x, 12'h003);
      for (int f = 0; f < 5; f++) begin
         frame_go();
         for (int x = 0; x < 4; x++) pixel(x, 12'h00C);
         for (int x = 0; x < 4; x++) pixel(x, 12'h003);
      end
      end_phase();

      // R7: pixel in the sof cycle uses new-frame state
      cur_req = "R7";
      write_reg(5, 3, 28'h0000F00);
      for (int f = 0; f < 6; f++) begin
         sof_pixel(0, 12'h00D);
         for (int x = 1; x < 8; x++) pixel(x, 12'h00D);
      end
      end_phase();

      // R8: colour mode, independent components
      cur_req = "R8";
      @(negedge clk) color_mode = 1'b1;
      line_go();
      for (int f = 0; f < 6; f++) begin
         frame_go();
         for (int s = 0; s < 16; s++) pixel(s, {4'(s), 4'((s * 5 + 3) % 16), 4'(15 - s)});
         for (int s = 0; s < 8; s++) pixel(s, {4'(s + 4), 4'(s + 4), 4'(11 - s)});
      end
      line_go();
      end_phase();
      @(negedge clk) color_mode = 1'b0;
      line_go();

      // R9: bit order and two-edge latency
      cur_req = "R9";
      frame_go();
      pixel(0, 12'h000); pixel(1, 12'h00F); pixel(2, 12'h00F); pixel(3, 12'h000);
      idle(1);
      checks++;
      if (lcd_valid !== 1'b0) begin
         fails++;
         $display("FAIL R9: valid=%b one edge after last pixel, expected 0", lcd_valid);
      end
      idle(1);
      checks++;
      if (lcd_valid !== 1'b1 || lcd_data !== 4'b0110) begin
         fails++;
         $display("FAIL R9: valid=%b data=%b expected 1/0110", lcd_valid, lcd_data);
      end
      end_phase();

      // R10: strobes discard partial words
      cur_req = "R10";
      pixel(0, 12'h00F); pixel(1, 12'h00F);
      line_go();
      for (int x = 0; x < 4; x++) pixel(x, 12'h009);
      pixel(0, 12'h00F); pixel(1, 12'h00F); pixel(2, 12'h00F);
      sol_pixel(0, 12'h000);
      for (int x = 1; x < 4; x++) pixel(x, 12'h00F);
      pixel(0, 12'h00F);
      sof_pixel(0, 12'h00F);
      for (int x = 1; x < 4; x++) pixel(x, 12'h000);
      @(negedge clk) color_mode = 1'b1;
      line_go();
      pixel(0, 12'hFFF);
      line_go();
      pixel(1, 12'hF0F); pixel(2, 12'h0F0);
      line_go();
      end_phase();

      finish_run();
   end
endmodule